// File: doc/BRIEF.md
# Interrupt Vector Table Register File

This block stores the programmable entries of a message-signalled interrupt vector table. Each entry has four 32-bit words: the low and high halves of the message address, the message payload, and a control word. The low bit of the control word masks the vector. The number of entries is a parameter, up to 2048. Software reaches the table through a simple request port that carries a byte offset, a size code and a 64-bit little-endian data lane. Each entry spans 16 bytes. Accesses may be 4 or 8 bytes wide.

The block returns read data one cycle after the request, together with a valid strobe. Any access it cannot honour reads as all ones and leaves the table untouched. Such an access is one with an unsupported size, a misaligned word or an index past the last entry. The block drives the mask bit of every entry as a flat vector. When a write really alters an entry, it emits a one-cycle change pulse carrying the entry index and the mask bit before and after the write, so that pending-interrupt logic can react to an unmask. A write that leaves the entry as it was produces no pulse. Message delivery, capability registers and address-window decoding sit outside this block.

Top module: `vec_table`

## Requirements
- R1: A 4-byte access (size code 2'b10) selects the word by offset bits [3:0]: 0x0 address low, 0x4 address high, 0x8 message data, 0xC control. The entry index is the offset divided by 16. Read data sits in bits 31:0 with bits 63:32 zero, and `rd_valid` rises exactly one cycle after the request.
- R2: An 8-byte access (size code 2'b11) at in-entry offset 0x0 transfers {address high, address low}, and at 0x8 transfers {control, data}. The lower-addressed word is in bits 31:0.
- R3: A 4-byte access at an in-entry offset other than 0x0, 0x4, 0x8 or 0xC reads 64'hFFFF_FFFF_FFFF_FFFF, and as a write it changes nothing.
- R4: An 8-byte access at an in-entry offset other than 0x0 or 0x8 reads all ones, and as a write it changes nothing.
- R5: Size codes 2'b00 (1 byte) and 2'b01 (2 bytes) are unsupported: they read all ones and do not write.
- R6: An access whose entry index is at or beyond NUM_VEC reads all ones and does not write.
- R7: After reset every entry holds zero address and data and control word 0x1, so `mask_o` is all ones.
- R8: `mask_o[i]` equals bit 0 of entry i's control word and follows a write from the cycle after it.
- R9: A write that alters an entry raises `chg_valid` for one cycle, one cycle after the request, with `chg_index` set to that entry and `chg_old_mask`/`chg_new_mask` set to its mask bit before and after the write.
- R10: A write that leaves the entry identical raises no `chg_valid`, and no read ever does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset into the table |
| req_size | input | 2 | Size code: 2'b10 = 4 bytes, 2'b11 = 8 bytes, others unsupported |
| req_wdata | input | 64 | Little-endian write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| mask_o | output | NUM_VEC | Per-vector mask bits |
| chg_valid | output | 1 | Entry-changed pulse |
| chg_index | output | IDX_W | Index of the changed entry |
| chg_old_mask | output | 1 | Mask bit before the change |
| chg_new_mask | output | 1 | Mask bit after the change |

## Verification
The table is written with 4-byte stores to every word position and with 8-byte stores at both legal positions. The bench reads each result back both ways. This shows whether lanes are swapped, words are mis-selected or 8-byte halves are reversed. Each kind of bad access is tried on its own, as a read and as a write: a misaligned dword, a misaligned qword, the two unsupported sizes, and an index one past the last entry. A readback after each write shows that only the decode rule in question rejected it. Repeating an identical write, masking and unmasking an entry, and writing the last entry test whether the change pulse depends on a true difference, reports the right mask edge and decodes the highest index.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_QWORD = 2'b11
    } acc_size_e;

    localparam int WORD_W      = 32;
    localparam int WORDS       = 4;
    localparam int ENTRY_BYTES = 16;
    localparam int MAX_VEC     = 2048;

    localparam logic [WORD_W-1:0] CTRL_AT_RESET = 32'h0000_0001;

    // word 0 = address low ... word 3 = control (packed lowest first)
    typedef logic [WORDS-1:0][WORD_W-1:0] entry_words_t;

    function automatic entry_words_t entry_reset();
        entry_words_t e;
        e    = '0;
        e[3] = CTRL_AT_RESET;
        return e;
    endfunction

endpackage

// File: rtl/vtbl_decode.sv
module vtbl_decode
    import vtbl_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = 8,
    localparam int IDX_W  = OFS_W - 4
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [IDX_W-1:0] idx,
    output logic [WORDS-1:0] word_en,
    output logic             is_qword,
    output logic             legal
);
    logic [3:0]       sub;
    logic             in_range;
    logic [WORDS-1:0] lane_en;

    assign idx      = offset[OFS_W-1:4];
    assign sub      = offset[3:0];
    assign in_range = int'(idx) < NUM_VEC;

    always_comb begin
        lane_en  = '0;
        is_qword = 1'b0;
        case (acc_size_e'(size))
            SZ_DWORD: begin
                case (sub)
                    4'h0:    lane_en = 4'b0001;
                    4'h4:    lane_en = 4'b0010;
                    4'h8:    lane_en = 4'b0100;
                    4'hC:    lane_en = 4'b1000;
                    default: lane_en = '0;
                endcase
            end
            SZ_QWORD: begin
                is_qword = 1'b1;
                case (sub)
                    4'h0:    lane_en = 4'b0011;
                    4'h8:    lane_en = 4'b1100;
                    default: lane_en = '0;
                endcase
            end
            default: lane_en = '0;
        endcase
    end

    assign word_en = in_range ? lane_en : '0;
    assign legal   = |word_en;
endmodule

// File: rtl/vtbl_entry.sv
module vtbl_entry
    import vtbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WORDS-1:0] word_en,
    input  logic             is_qword,
    input  logic [63:0]      wdata,
    output entry_words_t     cur,
    output logic             differs,
    output logic             next_mask
);
    entry_words_t nxt;

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic [WORD_W-1:0] lane;
        // odd words take the upper lane in an 8-byte access
        if (k % 2 == 1) begin : g_odd
            assign lane = is_qword ? wdata[63:32] : wdata[31:0];
        end else begin : g_even
            assign lane = wdata[31:0];
        end
        assign nxt[k] = word_en[k] ? lane : cur[k];
    end

    always_ff @(posedge clk) begin
        if (rst)        cur <= entry_reset();
        else if (wr_en) cur <= nxt;
    end

    assign differs   = wr_en && (nxt != cur);
    assign next_mask = nxt[3][0];
endmodule

// File: rtl/vec_table.sv
module vec_table
    import vtbl_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = $clog2(NUM_VEC) + 5,
    localparam int IDX_W  = OFS_W - 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [1:0]         req_size,
    input  logic [63:0]        req_wdata,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic [NUM_VEC-1:0] mask_o,
    output logic               chg_valid,
    output logic [IDX_W-1:0]   chg_index,
    output logic               chg_old_mask,
    output logic               chg_new_mask
);
    logic [IDX_W-1:0]   idx;
    logic [WORDS-1:0]   word_en;
    logic               is_qword;
    logic               legal;

    entry_words_t       ent   [NUM_VEC];
    logic [NUM_VEC-1:0] differs;
    logic [NUM_VEC-1:0] nmask;

    entry_words_t       sel_ent;
    logic               sel_old;
    logic               sel_new;
    logic [63:0]        rd_next;

    vtbl_decode #(.NUM_VEC(NUM_VEC), .OFS_W(OFS_W)) u_dec (
        .offset   (req_offset),
        .size     (req_size),
        .idx      (idx),
        .word_en  (word_en),
        .is_qword (is_qword),
        .legal    (legal)
    );

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
        logic hit;
        assign hit = req_valid && req_write && legal && (idx == IDX_W'(i));
        vtbl_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (hit),
            .word_en   (word_en),
            .is_qword  (is_qword),
            .wdata     (req_wdata),
            .cur       (ent[i]),
            .differs   (differs[i]),
            .next_mask (nmask[i])
        );
        assign mask_o[i] = ent[i][3][0];
    end

    always_comb begin
        sel_ent = '0;
        sel_old = 1'b0;
        sel_new = 1'b0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_ent = ent[i];
                sel_old = mask_o[i];
                sel_new = nmask[i];
            end
        end
    end

    always_comb begin
        rd_next = '1;
        if (legal) begin
            if (is_qword) begin
                rd_next = word_en[0] ? {sel_ent[1], sel_ent[0]} : {sel_ent[3], sel_ent[2]};
            end else begin
                rd_next = '0;
                for (int k = 0; k < WORDS; k++)
                    if (word_en[k]) rd_next[31:0] = sel_ent[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            chg_valid    <= 1'b0;
            chg_index    <= '0;
            chg_old_mask <= 1'b0;
            chg_new_mask <= 1'b0;
        end else begin
            rd_valid  <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= rd_next;
            chg_valid <= |differs;
            if (|differs) begin
                chg_index    <= idx;
                chg_old_mask <= sel_old;
                chg_new_mask <= sel_new;
            end
        end
    end
endmodule

// File: rtl/vtbl_checker.sv
module vtbl_checker #(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = 8,
    localparam int IDX_W  = OFS_W - 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [NUM_VEC-1:0] mask_o,
    input logic               rd_valid,
    input logic               chg_valid,
    input logic [IDX_W-1:0]   chg_index,
    input logic               chg_new_mask
);
    assert_rd_latency_R1: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_write));

    assert_reset_masked_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_o));

    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_valid && req_write)) |-> $stable(mask_o));

    assert_chg_range_R9: assert property (@(posedge clk) disable iff (rst)
        chg_valid |-> (int'(chg_index) < NUM_VEC));

    assert_chg_mask_R9: assert property (@(posedge clk) disable iff (rst)
        chg_valid |-> (mask_o[chg_index] == chg_new_mask));

    assert_chg_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
        chg_valid |-> $past(req_valid && req_write));
endmodule

bind vec_table vtbl_checker #(.NUM_VEC(NUM_VEC), .OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .mask_o       (mask_o),
    .rd_valid     (rd_valid),
    .chg_valid    (chg_valid),
    .chg_index    (chg_index),
    .chg_new_mask (chg_new_mask)
);

// File: tb/vec_table_test.sv
module vec_table_test;
    localparam int NV = 8;
    localparam int OW = 8;
    localparam int IW = OW - 4;
    localparam logic [1:0] S1 = 2'b00, S2 = 2'b01, S4 = 2'b10, S8 = 2'b11;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [OW-1:0] req_offset = '0;
    logic [1:0] req_size = 2'b10;
    logic [63:0] req_wdata = '0;
    logic rd_valid, chg_valid, chg_old_mask, chg_new_mask;
    logic [63:0] rd_data;
    logic [NV-1:0] mask_o;
    logic [IW-1:0] chg_index;

    int checks = 0, fails = 0;
    logic s_rv, s_cv, s_co, s_cn;
    logic [63:0] s_rd;
    logic [IW-1:0] s_ci;

    always #4 clk = ~clk;

    vec_table #(.NUM_VEC(NV)) uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [OW-1:0] ofs, input logic [1:0] sz,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
        @(negedge clk);
        s_rv = rd_valid; s_rd = rd_data; s_cv = chg_valid;
        s_ci = chg_index; s_co = chg_old_mask; s_cn = chg_new_mask;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [OW-1:0] ofs, input logic [1:0] sz,
                          input logic [63:0] exp);
        access(1'b0, ofs, sz, '0);
        check({tag, " rd_valid"}, 64'(s_rv), 64'd1);
        check({tag, " no pulse on read R10"}, 64'(s_cv), 64'd0);
        check(tag, s_rd, exp);
    endtask

    task automatic wr_nochg(input string tag, input logic [OW-1:0] ofs, input logic [1:0] sz,
                            input logic [63:0] wd);
        logic [NV-1:0] m;
        m = mask_o;
        access(1'b1, ofs, sz, wd);
        check({tag, " no pulse"}, 64'(s_cv), 64'd0);
        check({tag, " mask kept"}, 64'(mask_o), 64'(m));
    endtask

    task automatic wr_chg(input string tag, input logic [OW-1:0] ofs, input logic [1:0] sz,
                          input logic [63:0] wd, input int ix, input logic om, input logic nm);
        access(1'b1, ofs, sz, wd);
        check({tag, " pulse R9"}, 64'(s_cv), 64'd1);
        check({tag, " index R9"}, 64'(s_ci), 64'(ix));
        check({tag, " old mask R9"}, 64'(s_co), 64'(om));
        check({tag, " new mask R9"}, 64'(s_cn), 64'(nm));
    endtask

    task automatic t_reset();
        check("R7 mask after reset", 64'(mask_o), 64'hFF);
        check("R7 no pulse after reset", 64'(chg_valid), 64'd0);
        for (int i = 0; i < NV; i++) begin
            rd_chk("R7 ctrl reset", OW'(i * 16 + 12), S4, 64'h1);
            rd_chk("R7 entry qword reset", OW'(i * 16), S8, 64'h0);
        end
    endtask

    task automatic t_dword();
        wr_chg("R1 dword addr lo", 8'h00, S4, 64'hDEAD_0000_0000_1110, 0, 1'b1, 1'b1);
        wr_chg("R1 dword addr hi", 8'h04, S4, 64'h0000_1312, 0, 1'b1, 1'b1);
        wr_chg("R1 dword data", 8'h08, S4, 64'h0000_0020, 0, 1'b1, 1'b1);
        rd_chk("R1 read lo", 8'h00, S4, 64'h1110);
        rd_chk("R1 read hi", 8'h04, S4, 64'h1312);
        rd_chk("R1 read data", 8'h08, S4, 64'h20);
        rd_chk("R2 qword read at 0", 8'h00, S8, 64'h0000_1312_0000_1110);
        rd_chk("R2 qword read at 8", 8'h08, S8, 64'h0000_0001_0000_0020);
    endtask

    task automatic t_qword();
        wr_chg("R2 qword at 0", 8'h10, S8, 64'h0000_4443_0000_4241, 1, 1'b1, 1'b1);
        rd_chk("R2 low word", 8'h10, S4, 64'h4241);
        rd_chk("R2 high word", 8'h14, S4, 64'h4443);
        wr_chg("R2 qword at 8 unmask", 8'h28, S8, 64'h0000_0000_0000_0021, 2, 1'b1, 1'b0);
        check("R8 mask after unmask", 64'(mask_o), 64'hFB);
        rd_chk("R2 data word", 8'h28, S4, 64'h21);
        rd_chk("R2 ctrl word", 8'h2C, S4, 64'h0);
    endtask

    task automatic t_same();
        wr_nochg("R10 identical qword", 8'h28, S8, 64'h0000_0000_0000_0021);
        wr_nochg("R10 identical dword", 8'h14, S4, 64'h4443);
    endtask

    task automatic t_bad_dword();
        rd_chk("R3 dword offset 2", 8'h02, S4, ONES);
        rd_chk("R3 dword offset 0x1A", 8'h1A, S4, ONES);
        wr_nochg("R3 dword write offset 0x12", 8'h12, S4, 64'h5555);
        rd_chk("R3 entry1 kept", 8'h10, S8, 64'h0000_4443_0000_4241);
    endtask

    task automatic t_bad_qword();
        rd_chk("R4 qword offset 4", 8'h04, S8, ONES);
        wr_nochg("R4 qword write offset 0x14", 8'h14, S8, 64'h7777_7777_7777_7777);
        wr_nochg("R4 qword write offset 0x2C", 8'h2C, S8, 64'h1);
        rd_chk("R4 entry1 kept", 8'h10, S8, 64'h0000_4443_0000_4241);
        check("R4 mask kept", 64'(mask_o), 64'hFB);
    endtask

    task automatic t_bad_size();
        rd_chk("R5 size 1 byte", 8'h00, S1, ONES);
        rd_chk("R5 size 2 byte", 8'h00, S2, ONES);
        wr_nochg("R5 write size 2 byte", 8'h00, S2, 64'hAAAA);
        wr_nochg("R5 write size 1 byte", 8'h2C, S1, 64'h1);
        rd_chk("R5 entry0 kept", 8'h00, S4, 64'h1110);
    endtask

    task automatic t_range();
        rd_chk("R6 index NV dword", 8'h80, S4, ONES);
        rd_chk("R6 index NV qword", 8'h88, S8, ONES);
        wr_nochg("R6 write index NV ctrl", 8'h8C, S4, 64'h0);
        wr_nochg("R6 write index 15", 8'hF0, S8, 64'h1234);
        check("R6 mask kept", 64'(mask_o), 64'hFB);
    endtask

    task automatic t_edges();
        wr_chg("R9 unmask last entry", 8'h7C, S4, 64'h0, NV - 1, 1'b1, 1'b0);
        check("R8 mask last entry", 64'(mask_o), 64'h7B);
        wr_chg("R9 remask entry 2", 8'h2C, S4, 64'h1, 2, 1'b0, 1'b1);
        check("R8 mask remasked", 64'(mask_o), 64'h7F);
        wr_chg("R9 ctrl upper bits only", 8'h7C, S4, 64'h8000_0000, NV - 1, 1'b0, 1'b0);
        check("R8 mask ignores upper ctrl bits", 64'(mask_o), 64'h7F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dword();
        t_qword();
        t_same();
        t_bad_dword();
        t_bad_qword();
        t_bad_size();
        t_range();
        t_edges();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule